// File: doc/BRIEF.md
# Branch Target Address Cache

This block is a small, fully associative store that remembers where taken branches go. Each entry pairs the address of a branch instruction with the address it jumps to. The fetch stage presents its current fetch address on the lookup port. When a valid entry matches, the block returns the remembered destination within the same cycle, so the front end can steer the next fetch without waiting for target arithmetic. The default size is 32 entries.

The branch unit keeps the contents current through a maintenance port. It supplies the branch address, the computed destination and the direction that was predicted for that branch. Entries are created only for branches predicted taken. A branch predicted not taken removes its entry, if it has one, so that slots stay free for branches that actually redirect fetch. A new branch goes into the lowest-numbered free slot. When no slot is free, it replaces the slot named by a round-robin pointer, and only that case moves the pointer.

Top module: `brtgt_cache`

## Requirements
- R1: A synchronous active-high reset marks every entry empty and returns the replacement pointer to slot 0. The first lookup after reset misses, and once all slots are filled again, the first replacement lands in slot 0.
- R2: A lookup whose address matches a valid entry raises the hit output and presents that entry's stored destination in the same cycle (combinational path from the lookup address).
- R3: A lookup that matches no valid entry drives the hit output low and the target output to all zeros.
- R4: A maintenance request with the taken flag set, whose address is not cached, writes a new entry. The next cycle's lookup of that address hits with the supplied destination.
- R5: A taken request for an address that is already cached overwrites that entry's destination in place. It occupies no additional slot and leaves the replacement pointer where it was.
- R6: A request with the taken flag clear invalidates the matching entry, so lookups of that address miss from the next cycle on. If the address is not cached, the request changes nothing and allocates nothing.
- R7: While any slot is empty, a new entry goes into the lowest-numbered empty slot and no valid entry is displaced.
- R8: When all slots are valid, a new entry replaces the slot indicated by the round-robin pointer. The pointer then advances by one, wrapping from the last slot back to 0, and it moves only on such a replacement.
- R9: A maintenance request takes effect at the clock edge that ends its cycle. A lookup in the same cycle sees the contents as they were before the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lkp_pc | input | PC_W | Fetch address to look up |
| lkp_hit | output | 1 | A valid entry matches lkp_pc |
| lkp_target | output | TGT_W | Stored destination on hit, zero on miss |
| upd_valid | input | 1 | Maintenance request present this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_target | input | TGT_W | Computed destination of the branch |
| upd_taken | input | 1 | 1: predicted taken (allocate or refresh), 0: predicted not taken (invalidate) |

## Verification
The lookup path is exercised against an empty cache, a cache filling in order, and a cache full of distinct branches. These cases separate a true associative match from stale or default data, and they confirm that a miss returns zero. A lookup issued in the same cycle as a write shows that writes are not bypassed. The replacement policy is tested with interleaved sequences: invalidate-then-allocate, in-place refresh followed by a replacement, and two holes filled in an order that a later sweep of the pointer exposes. Together these tell lowest-free placement apart from pointer-driven placement, and they show that a pointer advancing on fills or refreshes would evict the wrong branch. A reset in the middle of the run, followed by a full refill, shows both that the entries are cleared and that the pointer returns to slot 0.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_REFRESH,
        ACT_FILL,
        ACT_EVICT,
        ACT_DROP
    } btc_act_e;

    function automatic int slot_after(input int cur, input int n);
        return (cur >= n - 1) ? 0 : cur + 1;
    endfunction

    function automatic logic writes_slot(input btc_act_e a);
        return (a == ACT_REFRESH) || (a == ACT_FILL) || (a == ACT_EVICT);
    endfunction

endpackage

// File: rtl/brtgt_store.sv
module brtgt_store #(
    parameter int N     = 32,
    parameter int TAG_W = 30,
    parameter int TGT_W = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TGT_W-1:0] wr_tgt,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [N-1:0]     valid,
    output logic [TAG_W-1:0] tags [N],
    output logic [TGT_W-1:0] tgts [N]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
        end else begin
            if (wr_en)  valid[wr_idx]  <= 1'b1;
            if (clr_en) valid[clr_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && wr_en) begin
            tags[wr_idx] <= wr_tag;
            tgts[wr_idx] <= wr_tgt;
        end
    end
endmodule

// File: rtl/brtgt_match.sv
module brtgt_match #(
    parameter int N     = 32,
    parameter int TAG_W = 30,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     valid,
    input  logic [TAG_W-1:0] tags [N],
    input  logic [TAG_W-1:0] key,
    output logic [N-1:0]     hit_vec,
    output logic             hit_any,
    output logic [IDX_W-1:0] hit_idx
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == key);
    end

    assign hit_any = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/brtgt_victim.sv
module brtgt_victim #(
    parameter int N = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     valid,
    input  logic             evict_use,
    output logic             free_any,
    output logic [IDX_W-1:0] free_idx,
    output logic [IDX_W-1:0] rr_ptr
);
    import brtgt_pkg::*;

    assign free_any = ~&valid;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
        end else if (evict_use) begin
            rr_ptr <= IDX_W'(slot_after(int'(rr_ptr), N));
        end
    end
endmodule

// File: rtl/brtgt_cache.sv
module brtgt_cache #(
    parameter int N_ENTRIES  = 32,
    parameter int PC_W       = 32,
    parameter int ALIGN_BITS = 2,
    parameter int TGT_W      = 32,
    localparam int TAG_W = PC_W - ALIGN_BITS,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PC_W-1:0]  lkp_pc,
    output logic             lkp_hit,
    output logic [TGT_W-1:0] lkp_target,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic [TGT_W-1:0] upd_target,
    input  logic             upd_taken
);
    import brtgt_pkg::*;

    typedef struct packed {
        btc_act_e         act;
        logic [IDX_W-1:0] idx;
    } btc_cmd_t;

    logic [N_ENTRIES-1:0] valid;
    logic [TAG_W-1:0]     tags [N_ENTRIES];
    logic [TGT_W-1:0]     tgts [N_ENTRIES];

    logic [N_ENTRIES-1:0] lk_vec, up_vec;
    logic                 lk_any, up_any;
    logic [IDX_W-1:0]     lk_idx, up_idx;
    logic                 free_any;
    logic [IDX_W-1:0]     free_idx, rr_ptr;
    logic                 evict_use;
    btc_cmd_t             cmd;

    brtgt_match #(.N(N_ENTRIES), .TAG_W(TAG_W)) u_lk_match (
        .valid(valid), .tags(tags), .key(lkp_pc[PC_W-1:ALIGN_BITS]),
        .hit_vec(lk_vec), .hit_any(lk_any), .hit_idx(lk_idx)
    );

    brtgt_match #(.N(N_ENTRIES), .TAG_W(TAG_W)) u_up_match (
        .valid(valid), .tags(tags), .key(upd_pc[PC_W-1:ALIGN_BITS]),
        .hit_vec(up_vec), .hit_any(up_any), .hit_idx(up_idx)
    );

    brtgt_victim #(.N(N_ENTRIES)) u_victim (
        .clk(clk), .rst(rst), .valid(valid), .evict_use(evict_use),
        .free_any(free_any), .free_idx(free_idx), .rr_ptr(rr_ptr)
    );

    always_comb begin
        cmd = '{act: ACT_IDLE, idx: '0};
        if (upd_valid) begin
            if (upd_taken) begin
                if (up_any)        cmd = '{act: ACT_REFRESH, idx: up_idx};
                else if (free_any) cmd = '{act: ACT_FILL,    idx: free_idx};
                else               cmd = '{act: ACT_EVICT,   idx: rr_ptr};
            end else if (up_any) begin
                cmd = '{act: ACT_DROP, idx: up_idx};
            end
        end
    end

    assign evict_use = (cmd.act == ACT_EVICT);

    brtgt_store #(.N(N_ENTRIES), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(writes_slot(cmd.act)), .wr_idx(cmd.idx),
        .wr_tag(upd_pc[PC_W-1:ALIGN_BITS]), .wr_tgt(upd_target),
        .clr_en(cmd.act == ACT_DROP), .clr_idx(cmd.idx),
        .valid(valid), .tags(tags), .tgts(tgts)
    );

    assign lkp_hit    = lk_any;
    assign lkp_target = lk_any ? tgts[lk_idx] : '0;
endmodule

// File: rtl/brtgt_checker.sv
module brtgt_checker #(
    parameter int N     = 32,
    parameter int PC_W  = 32,
    parameter int TGT_W = 32,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [PC_W-1:0]  lkp_pc,
    input logic             lkp_hit,
    input logic [TGT_W-1:0] lkp_target,
    input logic             upd_valid,
    input logic [PC_W-1:0]  upd_pc,
    input logic [TGT_W-1:0] upd_target,
    input logic             upd_taken,
    input logic [N-1:0]     lk_vec,
    input logic             evict_use,
    input logic [IDX_W-1:0] rr_ptr
);
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !lkp_hit);

    a_r3_miss_zero: assert property (@(posedge clk) disable iff (rst)
        !lkp_hit |-> (lkp_target == '0));

    a_r4_alloc_visible: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken) |=>
            ((lkp_pc != $past(upd_pc)) || (lkp_hit && lkp_target == $past(upd_target))));

    a_r6_drop_visible: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken) |=> ((lkp_pc != $past(upd_pc)) || !lkp_hit));

    a_r5_no_duplicate: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_vec));

    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !evict_use |=> $stable(rr_ptr));
endmodule

bind brtgt_cache brtgt_checker #(
    .N(N_ENTRIES), .PC_W(PC_W), .TGT_W(TGT_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .lkp_pc(lkp_pc), .lkp_hit(lkp_hit),
    .lkp_target(lkp_target), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_target(upd_target), .upd_taken(upd_taken), .lk_vec(lk_vec),
    .evict_use(evict_use), .rr_ptr(rr_ptr)
);

// File: tb/sim_brtgt_cache.sv
module sim_brtgt_cache;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lkp_pc = '0;
    logic        lkp_hit;
    logic [31:0] lkp_target;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic [31:0] upd_target = '0;
    logic        upd_taken = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic        hit;
        logic [31:0] tgt;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    brtgt_cache u0 (
        .clk(clk), .rst(rst), .lkp_pc(lkp_pc), .lkp_hit(lkp_hit),
        .lkp_target(lkp_target), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_target(upd_target), .upd_taken(upd_taken)
    );

    function automatic logic [31:0] pa(input int i);
        return 32'h0000_1000 + 32'(i) * 32'h40;
    endfunction
    function automatic logic [31:0] ta(input int i);
        return 32'h8000_0000 + 32'(i) * 32'h10;
    endfunction

    // monitor: compares the scoreboard head shortly after each falling edge
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (lkp_hit !== e.hit || lkp_target !== e.tgt) begin
                errors++;
                $display("FAIL %s: hit=%0b target=%h expected hit=%0b target=%h",
                         e.req, lkp_hit, lkp_target, e.hit, e.tgt);
            end
        end
    end

    task automatic look(input logic [31:0] pc, input logic hit,
                        input logic [31:0] tgt, input string req);
        @(negedge clk);
        upd_valid = 1'b0;
        lkp_pc = pc;
        sb.push_back('{hit, hit ? tgt : 32'h0, req});
    endtask

    task automatic upd(input logic [31:0] pc, input logic [31:0] tgt, input logic tk);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc = pc;
        upd_target = tgt;
        upd_taken = tk;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        look(pa(0), 1'b0, 0, "R1 empty after reset");
        look(32'h0000_7777 & ~32'h3, 1'b0, 0, "R3 miss gives zero");

        // R9: lookup in the same cycle as the write sees old contents
        upd(pa(0), ta(0), 1'b1);
        lkp_pc = pa(0);
        sb.push_back('{1'b0, 32'h0, "R9 same-cycle lookup misses"});
        look(pa(0), 1'b1, ta(0), "R4 allocated entry hits");

        for (int i = 1; i < N; i++) upd(pa(i), ta(i), 1'b1);
        for (int i = 0; i < N; i++) look(pa(i), 1'b1, ta(i), "R2 full cache hits");

        // R6: not-taken for an absent address has no effect
        upd(32'h0000_F000, 32'h1234_5678, 1'b0);
        look(32'h0000_F000, 1'b0, 0, "R6 absent not-taken allocates nothing");
        for (int i = 0; i < N; i++) look(pa(i), 1'b1, ta(i), "R6 absent not-taken keeps all");

        // R8: full cache replaces slot 0 first
        upd(32'h0000_B000, 32'h9000_0000, 1'b1);
        look(pa(0), 1'b0, 0, "R8 slot0 evicted");
        look(32'h0000_B000, 1'b1, 32'h9000_0000, "R8 new entry hits");
        look(pa(1), 1'b1, ta(1), "R8 slot1 kept");

        // R6 drop, R7 refill of the hole without eviction
        upd(pa(5), 0, 1'b0);
        look(pa(5), 1'b0, 0, "R6 dropped entry misses");
        upd(32'h0000_C000, 32'h9100_0000, 1'b1);
        look(32'h0000_C000, 1'b1, 32'h9100_0000, "R7 hole filled");
        look(pa(1), 1'b1, ta(1), "R7 no eviction while hole free");

        // R8: pointer did not move on the fill, next eviction is slot 1
        upd(32'h0000_D000, 32'h9200_0000, 1'b1);
        look(pa(1), 1'b0, 0, "R8 slot1 evicted");
        look(pa(2), 1'b1, ta(2), "R8 slot2 kept");
        look(32'h0000_C000, 1'b1, 32'h9100_0000, "R8 filled hole kept");

        // R5: refresh in place, pointer unchanged
        upd(pa(3), 32'hA000_0003, 1'b1);
        look(pa(3), 1'b1, 32'hA000_0003, "R5 target refreshed");
        upd(32'h0000_E000, 32'h9300_0000, 1'b1);
        look(pa(2), 1'b0, 0, "R5 refresh kept pointer, slot2 evicted");
        look(pa(3), 1'b1, 32'hA000_0003, "R5 refreshed entry kept");
        look(pa(4), 1'b1, ta(4), "R5 slot4 kept");

        // R7: two holes, slots 10 and 7; first fill must go to slot 7
        upd(pa(10), 0, 1'b0);
        upd(pa(7), 0, 1'b0);
        upd(32'h0002_0000, 32'h9400_0000, 1'b1);
        upd(32'h0002_1000, 32'h9500_0000, 1'b1);
        for (int i = 3; i <= 6; i++) upd(32'h0003_0000 + 32'(i) * 32'h40, ta(i + 100), 1'b1);
        look(32'h0002_0000, 1'b1, 32'h9400_0000, "R7 first fill still present");
        upd(32'h0003_0000 + 32'd7 * 32'h40, ta(107), 1'b1);
        look(32'h0002_0000, 1'b0, 0, "R7 first fill was in lowest slot 7");
        look(32'h0002_1000, 1'b1, 32'h9500_0000, "R7 second fill in slot 10");
        look(pa(8), 1'b1, ta(8), "R8 slot8 kept");

        // R1: reset in mid-run clears entries and pointer
        @(negedge clk);
        upd_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        look(pa(8), 1'b0, 0, "R1 reset clears entry");
        look(32'h0002_1000, 1'b0, 0, "R1 reset clears entry");
        for (int i = 0; i < N; i++) upd(32'h0005_0000 + 32'(i) * 32'h40, ta(i + 200), 1'b1);
        upd(32'h0006_0000, 32'h9600_0000, 1'b1);
        look(32'h0005_0000, 1'b0, 0, "R1 pointer back at slot 0");
        look(32'h0005_0040, 1'b1, ta(201), "R1 slot1 kept");
        look(32'h0006_0000, 1'b1, 32'h9600_0000, "R8 replacement hits");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule